// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block holds a 256-bit device secret as eight 32-bit words behind a simple word-addressed read port. Each word gives up its value exactly once after power-up. The read that returns the value also wipes that word's register, and the word reads as zero from then until the next power-on reset. Because a read always consumes the whole word, software must fetch each word with one full 32-bit access. If it reads one byte at a time, the first byte is correct and every later byte of that word comes back as zero.

An execution-mode input gates access. Only firmware mode may take the secret. In application mode every read returns zero and leaves the word untouched, so firmware can still fetch it later. The secret is loaded from a parameter on the power-on reset, which is the only event that clears the per-word consumed flags. Read data is registered and appears one cycle after the read strobe. A per-word consumed vector is exported for status.

Top module: `uds_store`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_data` is zero and every bit of `consumed` is zero.
- R2: The first firmware-mode read (`rd_en`=1, `fw_mode`=1) of word i (0 to 7) returns bits [32*i+31:32*i] of the `SECRET` parameter on `rd_data` in the cycle after the strobe.
- R3: A firmware-mode read sets `consumed[i]` in the cycle after the strobe, and every later read of word i returns zero.
- R4: A read with `fw_mode`=0 returns zero and leaves `consumed` unchanged, so a later firmware-mode read of that word still returns its secret value.
- R5: A read whose address is 8 or above (`rd_addr` is 4 bits) returns zero and changes no bit of `consumed`.
- R6: In the cycle after a cycle with `rd_en`=0, `rd_data` is zero.
- R7: A read sets at most one `consumed` bit, the one for the addressed word, and words that are not addressed keep their values.
- R8: `consumed` bits never clear except on reset, and a reset restores all eight secret words for fresh reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| fw_mode | input | 1 | 1 = firmware mode (read allowed), 0 = application mode |
| rd_addr | input | 4 | Word address; 0 to 7 are valid |
| rd_data | output | 32 | Registered read data, valid one cycle after the strobe |
| consumed | output | 8 | Bit i set once word i has been read |

## Verification
Some properties are checked on every cycle by assertions. These cover the stickiness of the consumed flags and the rule that a flag rises only after a firmware read of its own word. They also cover zero data after idle cycles, out-of-range reads, application-mode reads and reads of spent words, and the rule that no more than one flag rises per cycle. Other behaviour can only be shown by the bench scenarios, which compare against a reference model on every clock. That covers the actual secret values returned and their word order, and the check that an application-mode attempt leaves the word intact for later firmware use. It also covers the restoration of all words after a reset in the middle of a run, and the byte-at-a-time pattern of repeated reads of one word.

// File: rtl/uds_pkg.sv
package uds_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 8;
    localparam int IDX_W   = $clog2(N_WORDS);
    localparam int STORE_W = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [N_WORDS-1:0] flags_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } req_t;

    function automatic word_t word_of(logic [STORE_W-1:0] store, int i);
        return store[i*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/uds_req_decode.sv
module uds_req_decode
    import uds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              rd_en,
    input  logic              fw_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output req_t              req,
    output flags_t            take
);
    logic in_range;

    always_comb begin
        in_range = (rd_addr < ADDR_W'(N_WORDS));
        req.hit  = rd_en && fw_mode && in_range;
        req.idx  = rd_addr[IDX_W-1:0];
        take     = '0;
        if (req.hit) take[req.idx] = 1'b1;
    end
endmodule

// File: rtl/uds_word_slot.sv
module uds_word_slot
    import uds_pkg::*;
#(
    parameter word_t INIT = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    output word_t word_o,
    output logic  used_o
);
    word_t value_q;
    logic  used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= INIT;
            used_q  <= 1'b0;
        end else if (take) begin
            value_q <= '0;
            used_q  <= 1'b1;
        end
    end

    assign word_o = value_q;
    assign used_o = used_q;

    // R8
    used_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        used_q |=> used_q);

    // R3
    used_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(used_q) |-> $past(take));
endmodule

// File: rtl/uds_store.sv
module uds_store
    import uds_pkg::*;
#(
    parameter int                 ADDR_W = 4,
    parameter logic [STORE_W-1:0] SECRET = 256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_13579bdf_2468ace0_deadc0de_a5a5_5a5a
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              fw_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [N_WORDS-1:0] consumed
);
    req_t   req;
    flags_t take;
    word_t  slot_word [N_WORDS];
    flags_t used;
    word_t  data_q;

    uds_req_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd_en   (rd_en),
        .fw_mode (fw_mode),
        .rd_addr (rd_addr),
        .req     (req),
        .take    (take)
    );

    for (genvar i = 0; i < N_WORDS; i++) begin : g_slot
        uds_word_slot #(.INIT(word_of(SECRET, i))) u_slot (
            .clk    (clk),
            .rst    (rst),
            .take   (take[i]),
            .word_o (slot_word[i]),
            .used_o (used[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (req.hit) data_q <= slot_word[req.idx];
        else              data_q <= '0;
    end

    assign rd_data  = data_q;
    assign consumed = used;

    // R4
    app_no_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !fw_mode) |=> ($stable(consumed) && rd_data == '0));

    // R5
    out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= ADDR_W'(N_WORDS)) |=> ($stable(consumed) && rd_data == '0));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R3
    spent_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fw_mode && rd_addr < ADDR_W'(N_WORDS) && consumed[rd_addr[IDX_W-1:0]])
        |=> rd_data == '0);

    // R7
    single_consume_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(consumed & ~$past(consumed)));
endmodule

// File: tb/uds_store_test.sv
module uds_store_test;
    localparam logic [255:0] KEY =
        256'h11223344_55667788_99aabbcc_ddeeff00_cafef00d_0badbeef_76543210_fedcba98;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        fw_mode = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  consumed;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_word [8];
    bit          m_used [8];
    logic [31:0] m_data;
    bit          finished = 0;

    always #2 clk = ~clk;

    uds_store #(.ADDR_W(4), .SECRET(KEY)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .fw_mode(fw_mode),
        .rd_addr(rd_addr), .rd_data(rd_data), .consumed(consumed)
    );

    function automatic logic [7:0] m_flags();
        logic [7:0] f;
        for (int i = 0; i < 8; i++) f[i] = m_used[i];
        return f;
    endfunction

    task automatic step(input bit r, input bit en, input bit fw, input int a, input string tag);
        rst = r; rd_en = en; fw_mode = fw; rd_addr = 4'(a);
        @(posedge clk);
        if (r) begin
            m_data = '0;
            for (int i = 0; i < 8; i++) begin
                m_word[i] = KEY[i*32 +: 32];
                m_used[i] = 0;
            end
        end else if (en && fw && a < 8) begin
            m_data = m_used[a] ? 32'h0 : m_word[a];
            m_used[a] = 1;
        end else begin
            m_data = '0;
        end
        @(negedge clk);
        checks++;
        if (rd_data !== m_data || consumed !== m_flags()) begin
            errors++;
            $display("FAIL %s: data=%h consumed=%b expected data=%h consumed=%b",
                     tag, rd_data, consumed, m_data, m_flags());
        end
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, "R1");
        step(1, 1, 1, 2, "R1");
        step(0, 0, 0, 0, "R1");
        step(0, 1, 0, 0, "R4");
        step(0, 1, 0, 3, "R4");
        step(0, 1, 1, 0, "R2");
        step(0, 1, 1, 0, "R3");
        step(0, 0, 1, 0, "R6");
        step(0, 1, 1, 8, "R5");
        step(0, 1, 1, 15, "R5");
        step(0, 1, 0, 9, "R5");
        step(0, 1, 1, 3, "R2");
        step(0, 1, 1, 7, "R7");
        // byte-at-a-time style repeated reads of one word
        step(0, 1, 1, 5, "R2");
        step(0, 1, 1, 5, "R3");
        step(0, 1, 1, 5, "R3");
        step(0, 1, 0, 5, "R4");
        step(0, 0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) step(0, 1, 1, i, "R7");
        for (int i = 0; i < 8; i++) step(0, 1, 1, i, "R8");
        step(1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R1");
        for (int i = 7; i >= 0; i--) step(0, 1, 1, i, "R8");
        step(0, 1, 1, 4, "R3");
        step(0, 0, 0, 0, "R6");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #40000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule